// File: doc/BRIEF.md
# 64-bit Event Timer with Register Interface

This block is a timer peripheral built around a single 64-bit up-counter. Software programs it through a plain 32-bit register bus. Each access is one cycle, marked by a valid strobe and a write flag. Reads return data combinationally in the same cycle. Both the counter and the period are split into a low and a high 32-bit word. The counter is held at zero until a two-bit release field in the global control register is set to 11.

A two-bit mode field sits at bits [7:6] of the control register. It chooses between stopped (00), one-shot (01) and continuous (10). The value 11 is reserved and acts as stopped. When the count equals the programmed period, the block produces a match pulse one cycle long. In continuous mode the count then wraps to zero. In one-shot mode the count stays at the period and the mode field returns to 00. Each match sets a sticky status flag, and that flag drives the interrupt output when the interrupt enable is on.

Software normally uses it in three steps. Stop the timer by clearing the mode field. Write the counter and period words. Then set the mode with a final control write.

Top module: `evtmr_top`

## Requirements
- R1: After reset every mapped register reads 0, and both `period_hit` and `irq` are low.
- R2: The period words (0x18 low, 0x1C high), the control word (0x20) and the global control word (0x24) read back all 32 written bits. The counter words (0x10 low, 0x14 high) read back what was written while the timer is released from reset and stopped.
- R3: While global control bits [1:0] are not 11, the counter stays at zero. This holds when the mode field selects counting and when a counter word is written.
- R4: In continuous mode (control bits [7:6] = 10) the counter rises by one each clock. `period_hit` is high in the cycle where the count equals the period, and the count is 0 in the following cycle. A period of P therefore gives one match every P+1 cycles.
- R5: In one-shot mode (bits [7:6] = 01), after the match the count holds at the period value and bits [7:6] read 00. All other control bits keep their written values.
- R6: Writing 00 to the mode field stops the counter. The count then holds its value.
- R7: The count carries from the low word into the high word, and a match compares all 64 bits.
- R8: A period of 1 works: in continuous mode a match occurs every second cycle.
- R9: Status bit 1 of register 0x44 sets on each match and stays set until software writes 1 to it. A write with bit 1 = 0 leaves the flag unchanged, and a match in the same cycle as a clear wins.
- R10: `irq` is high exactly when the status flag (bit 1) and the enable (bit 0 of 0x44) are both set.
- R11: Reads of any offset other than 0x10, 0x14, 0x18, 0x1C, 0x20, 0x24 and 0x44 return 0, and writes to them change no register. `bus_rdata` is 0 when no read is under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid in the access cycle |
| period_hit | output | 1 | One-cycle pulse when the count equals the period |
| irq | output | 1 | Interrupt: status flag AND enable |

## Verification
The hardest case to reach from the ports is a carry out of the low counter word that lands exactly on a period spanning both words. Running up to 2^32 would take far too long. Instead, the stimulus preloads the counter just below the word boundary and sets the period high word one above the preloaded high word. The match then arrives two cycles after enable. The bench also places reads and pin checks on exact cycle offsets from the enabling write. This separates the wrap cycle in continuous mode from the hold cycle in one-shot mode, and covers a stop write that lands while the counter is still advancing.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

    localparam int unsigned OFS_W    = 8;
    localparam int unsigned MODE_LSB = 6;
    localparam int unsigned MODE_W   = 2;
    localparam int unsigned REL_W    = 2;
    localparam int unsigned ST_EN    = 0;
    localparam int unsigned ST_FLAG  = 1;
    localparam int unsigned N_HALF   = 2;

    localparam logic [OFS_W-1:0] OFS_CNT_LO = 8'h10;
    localparam logic [OFS_W-1:0] OFS_CNT_HI = 8'h14;
    localparam logic [OFS_W-1:0] OFS_PRD_LO = 8'h18;
    localparam logic [OFS_W-1:0] OFS_PRD_HI = 8'h1C;
    localparam logic [OFS_W-1:0] OFS_CTRL   = 8'h20;
    localparam logic [OFS_W-1:0] OFS_GCTL   = 8'h24;
    localparam logic [OFS_W-1:0] OFS_STAT   = 8'h44;

    typedef enum logic [MODE_W-1:0] {
        MODE_STOP = 2'b00,
        MODE_ONCE = 2'b01,
        MODE_LOOP = 2'b10,
        MODE_RSVD = 2'b11
    } tmr_mode_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CNT_LO,
        SEL_CNT_HI,
        SEL_PRD_LO,
        SEL_PRD_HI,
        SEL_CTRL,
        SEL_GCTL,
        SEL_STAT
    } reg_sel_e;

    typedef struct packed {
        logic [N_HALF-1:0] cnt;
        logic [N_HALF-1:0] prd;
        logic              ctrl;
        logic              gctl;
        logic              stat;
    } wr_strb_t;

    function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
        case (ofs)
            OFS_CNT_LO: return SEL_CNT_LO;
            OFS_CNT_HI: return SEL_CNT_HI;
            OFS_PRD_LO: return SEL_PRD_LO;
            OFS_PRD_HI: return SEL_PRD_HI;
            OFS_CTRL:   return SEL_CTRL;
            OFS_GCTL:   return SEL_GCTL;
            OFS_STAT:   return SEL_STAT;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic mode_counts(input tmr_mode_e m);
        return (m == MODE_ONCE) || (m == MODE_LOOP);
    endfunction

endpackage

// File: rtl/evtmr_decode.sv
module evtmr_decode
    import evtmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned BUS_W  = 32,
    localparam int unsigned CNT_W = N_HALF * BUS_W
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [CNT_W-1:0]  prd_q,
    input  logic [BUS_W-1:0]  ctrl_q,
    input  logic [BUS_W-1:0]  gctl_q,
    input  logic [BUS_W-1:0]  stat_rd,
    output wr_strb_t          strb,
    output logic [BUS_W-1:0]  rdata
);

    localparam logic [ADDR_W-1:0] HI_MASK = ~ADDR_W'({OFS_W{1'b1}});

    reg_sel_e sel;
    logic     in_page;

    always_comb begin
        in_page = ((bus_addr & HI_MASK) == '0);
        sel     = in_page ? decode_ofs(bus_addr[OFS_W-1:0]) : SEL_NONE;
    end

    always_comb begin
        strb = '0;
        if (bus_valid && bus_write) begin
            strb.cnt[0] = (sel == SEL_CNT_LO);
            strb.cnt[1] = (sel == SEL_CNT_HI);
            strb.prd[0] = (sel == SEL_PRD_LO);
            strb.prd[1] = (sel == SEL_PRD_HI);
            strb.ctrl   = (sel == SEL_CTRL);
            strb.gctl   = (sel == SEL_GCTL);
            strb.stat   = (sel == SEL_STAT);
        end
    end

    always_comb begin
        rdata = '0;
        if (bus_valid && !bus_write) begin
            case (sel)
                SEL_CNT_LO: rdata = cnt_q[0 +: BUS_W];
                SEL_CNT_HI: rdata = cnt_q[BUS_W +: BUS_W];
                SEL_PRD_LO: rdata = prd_q[0 +: BUS_W];
                SEL_PRD_HI: rdata = prd_q[BUS_W +: BUS_W];
                SEL_CTRL:   rdata = ctrl_q;
                SEL_GCTL:   rdata = gctl_q;
                SEL_STAT:   rdata = stat_rd;
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/evtmr_ctrl.sv
module evtmr_ctrl
    import evtmr_pkg::*;
#(
    parameter int unsigned BUS_W = 32,
    localparam int unsigned CNT_W = N_HALF * BUS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_strb_t         strb,
    input  logic [BUS_W-1:0] wdata,
    input  logic             once_done,
    output logic [CNT_W-1:0] prd_q,
    output logic [BUS_W-1:0] ctrl_q,
    output logic [BUS_W-1:0] gctl_q,
    output tmr_mode_e        mode,
    output logic             released
);

    for (genvar h = 0; h < N_HALF; h++) begin : g_prd
        always_ff @(posedge clk) begin
            if (rst) begin
                prd_q[h*BUS_W +: BUS_W] <= '0;
            end else if (strb.prd[h]) begin
                prd_q[h*BUS_W +: BUS_W] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (strb.ctrl) begin
            ctrl_q <= wdata;
        end else if (once_done) begin
            ctrl_q[MODE_LSB +: MODE_W] <= MODE_STOP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gctl_q <= '0;
        end else if (strb.gctl) begin
            gctl_q <= wdata;
        end
    end

    always_comb begin
        mode     = tmr_mode_e'(ctrl_q[MODE_LSB +: MODE_W]);
        released = &gctl_q[REL_W-1:0];
    end

endmodule

// File: rtl/evtmr_counter.sv
module evtmr_counter
    import evtmr_pkg::*;
#(
    parameter int unsigned BUS_W = 32,
    localparam int unsigned CNT_W = N_HALF * BUS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              released,
    input  tmr_mode_e         mode,
    input  logic [N_HALF-1:0] cnt_wr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  prd_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              hit
);

    logic             run_en;
    logic [CNT_W-1:0] cnt_adv;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        run_en = released && mode_counts(mode);
        hit    = run_en && (cnt_q == prd_q);
        if (!run_en) begin
            cnt_adv = cnt_q;
        end else if (hit) begin
            cnt_adv = (mode == MODE_LOOP) ? '0 : cnt_q;
        end else begin
            cnt_adv = cnt_q + 1'b1;
        end
    end

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        assign cnt_d[h*BUS_W +: BUS_W] = cnt_wr[h] ? wdata : cnt_adv[h*BUS_W +: BUS_W];
    end

    always_ff @(posedge clk) begin
        if (rst || !released) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/evtmr_irq.sv
module evtmr_irq
    import evtmr_pkg::*;
#(
    parameter int unsigned BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stat_wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic             hit,
    output logic             ien,
    output logic             flag,
    output logic [BUS_W-1:0] stat_rd,
    output logic             irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien  <= 1'b0;
            flag <= 1'b0;
        end else begin
            if (stat_wr) begin
                ien <= wdata[ST_EN];
            end
            if (hit) begin
                flag <= 1'b1;
            end else if (stat_wr && wdata[ST_FLAG]) begin
                flag <= 1'b0;
            end
        end
    end

    always_comb begin
        stat_rd          = '0;
        stat_rd[ST_EN]   = ien;
        stat_rd[ST_FLAG] = flag;
        irq              = flag && ien;
    end

endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
    import evtmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              period_hit,
    output logic              irq
);

    localparam int unsigned CNT_W = N_HALF * BUS_W;

    wr_strb_t         strb;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] prd_q;
    logic [BUS_W-1:0] ctrl_q;
    logic [BUS_W-1:0] gctl_q;
    logic [BUS_W-1:0] stat_rd;
    tmr_mode_e        mode;
    logic             released;
    logic             once_done;
    logic             stat_ien;
    logic             stat_flag;

    assign once_done = period_hit && (mode == MODE_ONCE);

    evtmr_decode #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .cnt_q     (cnt_q),
        .prd_q     (prd_q),
        .ctrl_q    (ctrl_q),
        .gctl_q    (gctl_q),
        .stat_rd   (stat_rd),
        .strb      (strb),
        .rdata     (bus_rdata)
    );

    evtmr_ctrl #(.BUS_W(BUS_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .strb      (strb),
        .wdata     (bus_wdata),
        .once_done (once_done),
        .prd_q     (prd_q),
        .ctrl_q    (ctrl_q),
        .gctl_q    (gctl_q),
        .mode      (mode),
        .released  (released)
    );

    evtmr_counter #(.BUS_W(BUS_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .released (released),
        .mode     (mode),
        .cnt_wr   (strb.cnt),
        .wdata    (bus_wdata),
        .prd_q    (prd_q),
        .cnt_q    (cnt_q),
        .hit      (period_hit)
    );

    evtmr_irq #(.BUS_W(BUS_W)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .stat_wr (strb.stat),
        .wdata   (bus_wdata),
        .hit     (period_hit),
        .ien     (stat_ien),
        .flag    (stat_flag),
        .stat_rd (stat_rd),
        .irq     (irq)
    );

endmodule

// File: rtl/evtmr_chk.sv
module evtmr_chk
    import evtmr_pkg::*;
#(
    parameter int unsigned BUS_W = 32,
    localparam int unsigned CNT_W = N_HALF * BUS_W
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              period_hit,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt_q,
    input tmr_mode_e         mode,
    input logic              released,
    input logic              stat_flag,
    input logic              stat_ien,
    input logic [N_HALF-1:0] cnt_wr,
    input logic              ctrl_wr,
    input logic              stat_wr
);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !released |=> (cnt_q == '0));

    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (period_hit && mode == MODE_LOOP && cnt_wr == '0) |=> (cnt_q == '0));

    p_once_stop_r5: assert property (@(posedge clk) disable iff (rst)
        (period_hit && mode == MODE_ONCE && !ctrl_wr) |=> (mode == MODE_STOP && !period_hit));

    p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (released && !mode_counts(mode) && cnt_wr == '0) |=> $stable(cnt_q));

    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        (released && mode_counts(mode) && !period_hit && cnt_wr == '0)
        |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (stat_flag && !(stat_wr && bus_wdata[ST_FLAG])) |=> stat_flag);

    p_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (period_hit && stat_ien && !(stat_wr && !bus_wdata[ST_EN])) |=> irq);

    p_rd_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !bus_write) |-> (bus_rdata == '0));

endmodule

bind evtmr_top evtmr_chk #(.BUS_W(BUS_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .period_hit (period_hit),
    .irq        (irq),
    .cnt_q      (cnt_q),
    .mode       (mode),
    .released   (released),
    .stat_flag  (stat_flag),
    .stat_ien   (stat_ien),
    .cnt_wr     (strb.cnt),
    .ctrl_wr    (strb.ctrl),
    .stat_wr    (strb.stat)
);

// File: tb/tb_evtmr_top.sv
module tb_evtmr_top;

    localparam int CLK_PERIOD   = 10;
    localparam int WATCHDOG_CYC = 5000;

    localparam logic [7:0] A_CNT_LO = 8'h10;
    localparam logic [7:0] A_CNT_HI = 8'h14;
    localparam logic [7:0] A_PRD_LO = 8'h18;
    localparam logic [7:0] A_PRD_HI = 8'h1C;
    localparam logic [7:0] A_CTRL   = 8'h20;
    localparam logic [7:0] A_GCTL   = 8'h24;
    localparam logic [7:0] A_STAT   = 8'h44;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        period_hit;
    logic        irq;

    typedef struct {
        bit          is_pin;
        logic [31:0] exp_data;
        logic        exp_hit;
        logic        exp_irq;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    logic mon_req = 1'b0;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    evtmr_top dut (
        .clk        (clk),
        .rst        (rst),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .period_hit (period_hit),
        .irq        (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pops one expected item per requested cycle
    always @(negedge clk) begin
        if (mon_req) begin
            exp_t e;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL bench: scoreboard empty");
            end else begin
                e = sb_q.pop_front();
                n_vec++;
                if (e.is_pin) begin
                    if (period_hit !== e.exp_hit || irq !== e.exp_irq) begin
                        n_bad++;
                        $display("FAIL %s: hit=%0b irq=%0b expected hit=%0b irq=%0b",
                                 e.tag, period_hit, irq, e.exp_hit, e.exp_irq);
                    end
                end else if (bus_rdata !== e.exp_data) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h expected %h", e.tag, bus_rdata, e.exp_data);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        e.is_pin = 1'b0; e.exp_data = exp; e.exp_hit = 1'b0; e.exp_irq = 1'b0; e.tag = tag;
        sb_q.push_back(e);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; mon_req = 1'b1;
        @(posedge clk); #1;
        bus_valid = 1'b0; mon_req = 1'b0;
    endtask

    task automatic pin(input logic h, input logic i, input string tag);
        exp_t e;
        e.is_pin = 1'b1; e.exp_data = '0; e.exp_hit = h; e.exp_irq = i; e.tag = tag;
        sb_q.push_back(e);
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected end before %0d cycles", WATCHDOG_CYC);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(A_CNT_LO, 32'h0, "R1 cnt lo");
        rd(A_CNT_HI, 32'h0, "R1 cnt hi");
        rd(A_PRD_LO, 32'h0, "R1 prd lo");
        rd(A_PRD_HI, 32'h0, "R1 prd hi");
        rd(A_CTRL,   32'h0, "R1 ctrl");
        rd(A_GCTL,   32'h0, "R1 gctl");
        rd(A_STAT,   32'h0, "R1 stat");
        pin(1'b0, 1'b0, "R1 pins");

        // R2 readback
        wr(A_PRD_LO, 32'h1234_5678);
        wr(A_PRD_HI, 32'h9abc_def0);
        wr(A_CTRL,   32'h0000_0a05);
        wr(A_GCTL,   32'h0000_0003);
        wr(A_CNT_LO, 32'hdead_beef);
        wr(A_CNT_HI, 32'h0000_0001);
        rd(A_CNT_LO, 32'hdead_beef, "R2 cnt lo");
        rd(A_CNT_HI, 32'h0000_0001, "R2 cnt hi");
        rd(A_PRD_LO, 32'h1234_5678, "R2 prd lo");
        rd(A_PRD_HI, 32'h9abc_def0, "R2 prd hi");
        rd(A_CTRL,   32'h0000_0a05, "R2 ctrl");
        rd(A_GCTL,   32'h0000_0003, "R2 gctl");

        // R3 held in reset
        wr(A_GCTL, 32'h0);
        wr(A_CNT_LO, 32'h5);
        wr(A_CTRL, 32'h80);
        idle(3);
        rd(A_CNT_LO, 32'h0, "R3 cnt lo held");
        rd(A_CNT_HI, 32'h0, "R3 cnt hi held");
        wr(A_CTRL, 32'h0);

        // R4 continuous, period 3
        wr(A_GCTL, 32'h3);
        wr(A_PRD_LO, 32'h3);
        wr(A_PRD_HI, 32'h0);
        wr(A_CTRL, 32'h80);
        rd(A_CNT_LO, 32'h0, "R4 count c0");
        rd(A_CNT_LO, 32'h1, "R4 count c1");
        pin(1'b0, 1'b0, "R4 no hit c2");
        pin(1'b1, 1'b0, "R4 hit c3");
        rd(A_CNT_LO, 32'h0, "R4 wrap c4");
        idle(2);
        pin(1'b1, 1'b0, "R4 second hit c7");
        rd(A_STAT, 32'h2, "R9 flag set");
        // R6 stop
        wr(A_CTRL, 32'h0);
        idle(3);
        rd(A_CNT_LO, 32'h2, "R6 count frozen");

        // R5 one-shot, period 2
        wr(A_STAT, 32'h2);
        wr(A_CNT_LO, 32'h0);
        wr(A_PRD_LO, 32'h2);
        wr(A_CTRL, 32'h0000_1140);
        idle(2);
        pin(1'b1, 1'b0, "R5 hit");
        pin(1'b0, 1'b0, "R5 single pulse");
        rd(A_CNT_LO, 32'h2, "R5 held at period");
        rd(A_CTRL, 32'h0000_1100, "R5 mode cleared");
        idle(3);
        rd(A_CNT_LO, 32'h2, "R5 still held");

        // R8 period 1, R10 irq
        wr(A_CNT_LO, 32'h0);
        wr(A_PRD_LO, 32'h1);
        wr(A_STAT, 32'h3);
        wr(A_CTRL, 32'h80);
        pin(1'b0, 1'b0, "R8 c0");
        pin(1'b1, 1'b0, "R8 hit c1");
        pin(1'b0, 1'b1, "R10 irq c2");
        pin(1'b1, 1'b1, "R8 hit c3");
        wr(A_CTRL, 32'h0);
        pin(1'b0, 1'b1, "R9 sticky after stop");
        wr(A_STAT, 32'h1);
        pin(1'b0, 1'b1, "R9 no clear with bit1=0");
        wr(A_STAT, 32'h0);
        pin(1'b0, 1'b0, "R10 masked");
        rd(A_STAT, 32'h2, "R9 flag kept");
        wr(A_STAT, 32'h2);
        rd(A_STAT, 32'h0, "R9 cleared");

        // R7 carry into high word, 64-bit match
        wr(A_CNT_LO, 32'hffff_fffe);
        wr(A_CNT_HI, 32'h7);
        wr(A_PRD_LO, 32'h0);
        wr(A_PRD_HI, 32'h8);
        wr(A_CTRL, 32'h80);
        rd(A_CNT_LO, 32'hffff_fffe, "R7 c0");
        rd(A_CNT_HI, 32'h7, "R7 c1 hi");
        pin(1'b1, 1'b0, "R7 64-bit hit");
        rd(A_CNT_LO, 32'h0, "R7 wrap lo");
        rd(A_CNT_HI, 32'h0, "R7 wrap hi");
        wr(A_CTRL, 32'h0);

        // R11 unmapped
        wr(8'h30, 32'hffff_ffff);
        wr(8'h11, 32'hffff_ffff);
        rd(8'h30, 32'h0, "R11 read 0x30");
        rd(8'h11, 32'h0, "R11 read 0x11");
        rd(A_PRD_HI, 32'h8, "R11 prd hi kept");
        rd(A_PRD_LO, 32'h0, "R11 prd lo kept");
        rd(A_CTRL, 32'h0, "R11 ctrl kept");
        rd(A_GCTL, 32'h3, "R11 gctl kept");
        rd(A_STAT, 32'h2, "R11 stat kept");

        idle(2);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL bench: %0d items left, expected 0", sb_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule